// File: doc/BRIEF.md
# Keyed Lockable System Control Register

This block is a 16-bit control register that sits on a simple single-cycle register bus. It does two jobs. First, it holds a lock flag that decides whether a bridge's other configuration registers may be written. Second, it holds the bit that drives an active-low reset line to a downstream bus.

Once the lock is set, the register ignores every write except one: a write of the 16-bit unlock key, 0xA05F. That write clears the lock. While the register is unlocked, an ordinary write updates both bits. Software can therefore re-lock by reading the register, setting the lock bit and writing the value back.

The register is a two-state machine:
- `ST_OPEN` is the unlocked state. An ordinary write may update the reset-out bit. A write with the lock bit set takes the transition `SEAL` to `ST_SEALED`.
- `ST_SEALED` is the locked state. A write of the key takes the transition `UNSEAL` back to `ST_OPEN`.
- Every other combination of state and write is the self-loop `HOLD`.

The block exports three signals to its neighbours: the lock status, a write-enable gate for the protected registers, and the downstream reset pin.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After reset the register is unlocked and the downstream reset is asserted. `bus_rst_n` is 0, `locked` is 0, `cfg_wr_allow` is 1 and `rd_data` reads 0x0000.
- R2: While unlocked, a write copies data bit 15 to `bus_rst_n` and data bit 14 to `locked`. Both take effect on the clock edge that samples the write.
- R3: While locked, a write of any value other than 0xA05F changes nothing. The lock stays set and `bus_rst_n` keeps its value.
- R4: While locked, a write of exactly 0xA05F clears the lock on the next edge and leaves `bus_rst_n` unchanged.
- R5: While unlocked, a write of 0xA05F is an ordinary write. It sets `bus_rst_n` to 1 and leaves the register unlocked.
- R6: `rd_data` always returns the reset-out bit in bit 15 and the lock bit in bit 14. Bits 13 down to 0 read as zero, whatever value was written to them.
- R7: `cfg_wr_allow` is always the inverse of the lock bit, so it changes on the same edge as the lock.
- R8: A cycle with `wr_en` low changes neither bit, even if `wr_data` holds the key.
- R9: A read-modify-write that sets bit 14 re-locks the register on the next edge. A later non-key write is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| locked | output | 1 | Lock status |
| cfg_wr_allow | output | 1 | Write-enable gate for the protected registers |
| bus_rst_n | output | 1 | Downstream bus reset, active low |

## Verification
The bound checker watches four things on every clock:
- how a write in each state moves the two bits, including key and non-key writes while locked;
- that idle cycles leave both bits alone;
- that the gate stays the inverse of the lock;
- that the unused read bits stay zero.

The reset values, and the full ordering of sealing, unsealing and re-sealing, can only be shown by the bench. In particular, an unlock preserves whichever reset-out value was present, and a near-miss key leaves the register locked.

// File: rtl/guard_pkg.sv
package guard_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_SEALED = 1'b1
    } guard_state_e;
endpackage

// File: rtl/guard_key_match.sv
module guard_key_match #(
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY    = 16'hA05F
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_hit
);
    localparam logic [DATA_W-1:0] KEY_EXT = DATA_W'(KEY);

    always_comb begin
        key_hit = wr_en && (wr_data == KEY_EXT);
    end
endmodule

// File: rtl/guard_lock_fsm.sv
module guard_lock_fsm
    import guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_lock_bit,
    input  logic         wr_rst_bit,
    input  logic         key_hit,
    output guard_state_e state,
    output logic         rst_out
);
    guard_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: SEAL, UNSEAL, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: begin
                if (wr_en && wr_lock_bit) begin
                    state_nx = ST_SEALED;
                end
            end
            ST_SEALED: begin
                if (key_hit) begin
                    state_nx = ST_OPEN;
                end
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    // Output bit: only an ordinary write in ST_OPEN moves the reset-out bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_out <= 1'b0;
        end else begin
            unique case (state)
                ST_OPEN: begin
                    if (wr_en) begin
                        rst_out <= wr_rst_bit;
                    end
                end
                ST_SEALED: begin
                    rst_out <= rst_out;
                end
                default: rst_out <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/guard_read_mux.sv
module guard_read_mux #(
    parameter int DATA_W   = 16,
    parameter int LOCK_POS = 14,
    parameter int RST_POS  = 15
) (
    input  logic              lock_bit,
    input  logic              rst_bit,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == LOCK_POS) begin : g_lock
            assign rd_data[i] = lock_bit;
        end else if (i == RST_POS) begin : g_rst
            assign rd_data[i] = rst_bit;
        end else begin : g_zero
            assign rd_data[i] = 1'b0;
        end
    end
endmodule

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg
    import guard_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          LOCK_POS   = 14,
    parameter int          RST_POS    = 15,
    parameter logic [15:0] UNLOCK_KEY = 16'hA05F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              locked,
    output logic              cfg_wr_allow,
    output logic              bus_rst_n
);
    localparam int POS_MAX = (LOCK_POS > RST_POS) ? LOCK_POS : RST_POS;

    initial begin
        if (POS_MAX >= DATA_W || LOCK_POS == RST_POS) begin
            $error("guarded_ctrl_reg: bit positions out of range or equal");
        end
    end

    guard_state_e state;
    logic         key_hit;
    logic         rst_bit;

    guard_key_match #(
        .DATA_W (DATA_W),
        .KEY    (UNLOCK_KEY)
    ) u_key (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .key_hit (key_hit)
    );

    guard_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_lock_bit (wr_data[LOCK_POS]),
        .wr_rst_bit  (wr_data[RST_POS]),
        .key_hit     (key_hit),
        .state       (state),
        .rst_out     (rst_bit)
    );

    guard_read_mux #(
        .DATA_W   (DATA_W),
        .LOCK_POS (LOCK_POS),
        .RST_POS  (RST_POS)
    ) u_rd (
        .lock_bit (locked),
        .rst_bit  (rst_bit),
        .rd_data  (rd_data)
    );

    assign locked       = (state == ST_SEALED);
    assign cfg_wr_allow = !locked;
    assign bus_rst_n    = rst_bit;
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
    parameter int          DATA_W     = 16,
    parameter int          LOCK_POS   = 14,
    parameter int          RST_POS    = 15,
    parameter logic [15:0] UNLOCK_KEY = 16'hA05F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              locked,
    input logic              cfg_wr_allow,
    input logic              bus_rst_n
);
    localparam logic [DATA_W-1:0] KEY_EXT  = DATA_W'(UNLOCK_KEY);
    localparam logic [DATA_W-1:0] USED_MSK = (DATA_W'(1) << LOCK_POS) | (DATA_W'(1) << RST_POS);

    // R2
    open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && wr_en) |=> (locked == $past(wr_data[LOCK_POS]) && bus_rst_n == $past(wr_data[RST_POS])));

    // R3
    sealed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && wr_data != KEY_EXT) |=> (locked && $stable(bus_rst_n)));

    // R4
    unseal_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && wr_data == KEY_EXT) |=> (!locked && $stable(bus_rst_n)));

    // R6
    rd_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~USED_MSK) == '0) && rd_data[LOCK_POS] == locked && rd_data[RST_POS] == bus_rst_n);

    // R7
    gate_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_allow != locked);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(locked) && $stable(bus_rst_n)));
endmodule

bind guarded_ctrl_reg guard_chk #(
    .DATA_W     (DATA_W),
    .LOCK_POS   (LOCK_POS),
    .RST_POS    (RST_POS),
    .UNLOCK_KEY (UNLOCK_KEY)
) u_guard_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .locked       (locked),
    .cfg_wr_allow (cfg_wr_allow),
    .bus_rst_n    (bus_rst_n)
);

// File: tb/guarded_ctrl_reg_test.sv
module guarded_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        locked;
    logic        cfg_wr_allow;
    logic        bus_rst_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    guarded_ctrl_reg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .locked       (locked),
        .cfg_wr_allow (cfg_wr_allow),
        .bus_rst_n    (bus_rst_n)
    );

    // Each entry: {write enable, write data, expected read value after the edge}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 16'h8000, 16'h8000},
        {1'b1, 16'hC000, 16'hC000},
        {1'b1, 16'h0000, 16'hC000},
        {1'b1, 16'h4000, 16'hC000},
        {1'b1, 16'hA05E, 16'hC000},
        {1'b1, 16'hA05F, 16'h8000},
        {1'b1, 16'h0000, 16'h0000},
        {1'b1, 16'h4000, 16'h4000},
        {1'b1, 16'hFFFF, 16'h4000},
        {1'b0, 16'hA05F, 16'h4000},
        {1'b1, 16'hA05F, 16'h0000},
        {1'b1, 16'hA05F, 16'h8000},
        {1'b1, 16'h3FFF, 16'h0000},
        {1'b1, 16'hFFFF, 16'hC000}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 6, 7, 13: return "R2";
            2, 3, 4, 8:     return "R3";
            5, 10:          return "R4";
            9:              return "R8";
            11:             return "R5";
            default:        return "R6";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, logic [15:0] exp);
        chk(req, "rd_data", rd_data, exp);
        chk(req, "bus_rst_n", {15'h0, bus_rst_n}, {15'h0, exp[15]});
        chk(req, "locked", {15'h0, locked}, {15'h0, exp[14]});
        chk("R7", "cfg_wr_allow", {15'h0, cfg_wr_allow}, {15'h0, !exp[14]});
    endtask

    task automatic do_wr(logic en, logic [15:0] d);
        @(negedge clk);
        wr_en   = en;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] rb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_all("R1", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 16'h0000);

        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i][32], VEC[i][31:16]);
            chk_all(tag_of(i), VEC[i][15:0]);
        end

        // R4: unlock, then R9: read-modify-write re-lock
        do_wr(1'b1, 16'hA05F);
        chk_all("R4", 16'h8000);
        rb = rd_data;
        do_wr(1'b1, rb | 16'h4000);
        chk_all("R9", 16'hC000);
        do_wr(1'b1, 16'h0000);
        chk_all("R9", 16'hC000);

        // R1: reset while locked with the bus released
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 16'h0000);

        finish_run();
    end
endmodule